// File: doc/BRIEF.md
# Paged Direct Address Generator

This block turns a short instruction offset, or an absolute constant, into a complete memory address. It keeps three pointer registers. The data-page pointer and the stack pointer each hold a 7-bit page above a 16-bit base. The peripheral page register holds a 9-bit page above a 7-bit field that plays no part in forming addresses. Software can write the high field of any register, its low field, or the whole register at once.

For each request a mode code picks one rule:
- data-page direct
- stack direct
- peripheral direct
- 16-bit absolute
- 23-bit absolute

In data-page mode, a register-map qualifier forces the page and the base to zero, so the offset reaches the register space on page 0. Data addresses come out as 23 bits. I/O addresses come out as 16 bits, zero-extended, with an I/O indicator. Stack accesses that land in the register space raise a reserved flag.

The result is registered and appears one cycle after the request, together with a valid strobe. The block is used between instruction decode and the memory ports.

Top module: `pda_gen`

## Requirements
- R1: After synchronous reset, out_valid, out_is_io, out_rsvd and out_addr are 0, and all three pointer registers are 0.
- R2: When ld_valid is high, ld_sel picks the register: 0 = data pointer, 1 = stack pointer, 2 = peripheral page, 3 = none. ld_part picks what is written: 0 = high field only, taken from ld_value[6:0] (peripheral page: ld_value[8:0]); 1 = low field only, taken from ld_value[15:0] (peripheral: ld_value[6:0]); 2 = the whole register from the low bits of ld_value. A partial write leaves the other field unchanged.
- R3: Mode 0 (data-page direct) gives out_addr = {page, (base + offset) mod 2^16}. The sum never carries into the page field.
- R4: In mode 0 with req_mmr high, out_addr = offset zero-extended, as if the data pointer were 0. req_mmr has no effect in any other mode.
- R5: Mode 1 (stack direct) forms the address in the same way from the stack pointer.
- R6: out_rsvd is 1 only for a mode 1 request whose stack page is 0 and whose wrapped 16-bit sum is below 0x60. In every other case it is 0.
- R7: Mode 2 (peripheral direct) gives out_addr = {7'b0, page9, offset} and out_is_io = 1. Every other mode gives out_is_io = 0.
- R8: Mode 3 (16-bit absolute) gives out_addr = {7'b0, req_const[15:0]}.
- R9: Mode 4 (23-bit absolute) gives out_addr = req_const.
- R10: out_valid is high exactly in the cycle after a request with req_valid high and a mode from 0 to 4. Modes 5 to 7 and idle cycles give out_valid = 0 and leave out_addr unchanged.
- R11: A request issued in the same cycle as a pointer load uses the pointer value from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Pointer write strobe |
| ld_sel | input | 2 | Pointer register select |
| ld_part | input | 2 | Field select: high, low or whole |
| ld_value | input | 23 | Write data |
| req_valid | input | 1 | Address request strobe |
| req_mode | input | 3 | Addressing mode code |
| req_mmr | input | 1 | Register-map qualifier (mode 0 only) |
| req_offset | input | 7 | Instruction offset |
| req_const | input | 23 | Absolute constant |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_is_io | output | 1 | Address is in I/O space |
| out_addr | output | 23 | Formed address |
| out_rsvd | output | 1 | Stack access into the register space |

## Verification
The reserved flag is the hardest case to reach from the ports, because it needs a stack page of 0, a particular base and a particular offset at the same time. The stimulus writes the whole stack pointer to page 0 with a base just under 0x60. It then probes the offsets on both sides of the 0x60 boundary. It also loads a base near 0xFFFF, so that the wrapped sum falls back into the low region and must raise the flag. Partial loads are checked by writing one field and reading it back through a data-page request that shows the untouched field.

// File: rtl/pda_pkg.sv
package pda_pkg;

    localparam int PAGE_W_D    = 7;
    localparam int BASE_W_D    = 16;
    localparam int OFS_W_D     = 7;
    localparam int PORT_PG_W_D = 9;
    localparam int MMR_END_D   = 'h60;

    typedef enum logic [2:0] {
        AM_PAGE  = 3'd0,
        AM_STACK = 3'd1,
        AM_PORT  = 3'd2,
        AM_ABS16 = 3'd3,
        AM_ABS23 = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        LP_HIGH = 2'd0,
        LP_LOW  = 2'd1,
        LP_FULL = 2'd2
    } ld_part_e;

    typedef enum logic [1:0] {
        PS_DATA  = 2'd0,
        PS_STACK = 2'd1,
        PS_PORT  = 2'd2,
        PS_NONE  = 2'd3
    } ptr_sel_e;

    typedef struct packed {
        logic ok;
        logic is_io;
        logic rsvd;
    } addr_flags_t;

endpackage

// File: rtl/pda_ptr_reg.sv
module pda_ptr_reg
    import pda_pkg::*;
#(
    parameter int HI_W = 7,
    parameter int LO_W = 16,
    localparam int TOT_W = HI_W + LO_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  ld_part_e         wr_part,
    input  logic [TOT_W-1:0] wr_data,
    output logic [HI_W-1:0]  hi,
    output logic [LO_W-1:0]  lo
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi <= '0;
            lo <= '0;
        end else if (wr_en) begin
            case (wr_part)
                LP_HIGH: hi <= wr_data[HI_W-1:0];
                LP_LOW:  lo <= wr_data[LO_W-1:0];
                LP_FULL: {hi, lo} <= wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pda_addr_form.sv
module pda_addr_form
    import pda_pkg::*;
#(
    parameter int PAGE_W    = 7,
    parameter int BASE_W    = 16,
    parameter int OFS_W     = 7,
    parameter int PORT_PG_W = 9,
    parameter int MMR_END   = 'h60,
    localparam int ADDR_W   = PAGE_W + BASE_W
) (
    input  amode_e               mode,
    input  logic                 mmr,
    input  logic [OFS_W-1:0]     offset,
    input  logic [ADDR_W-1:0]    konst,
    input  logic [PAGE_W-1:0]    dp_hi,
    input  logic [BASE_W-1:0]    dp_lo,
    input  logic [PAGE_W-1:0]    sp_hi,
    input  logic [BASE_W-1:0]    sp_lo,
    input  logic [PORT_PG_W-1:0] pp_hi,
    output logic [ADDR_W-1:0]    addr,
    output addr_flags_t          flags
);

    logic [PAGE_W-1:0] op_page;
    logic [BASE_W-1:0] op_base;
    logic [BASE_W-1:0] sum;

    // operand select in front of the single shared adder
    always_comb begin
        op_page = '0;
        op_base = '0;
        case (mode)
            AM_PAGE: begin
                op_page = mmr ? '0 : dp_hi;
                op_base = mmr ? '0 : dp_lo;
            end
            AM_STACK: begin
                op_page = sp_hi;
                op_base = sp_lo;
            end
            default: ;
        endcase
    end

    assign sum = op_base + BASE_W'(offset);

    always_comb begin
        addr  = '0;
        flags = '{ok: 1'b1, is_io: 1'b0, rsvd: 1'b0};
        case (mode)
            AM_PAGE:  addr = {op_page, sum};
            AM_STACK: begin
                addr       = {op_page, sum};
                flags.rsvd = (op_page == '0) && (sum < BASE_W'(MMR_END));
            end
            AM_PORT: begin
                addr        = ADDR_W'({pp_hi, offset});
                flags.is_io = 1'b1;
            end
            AM_ABS16: addr = ADDR_W'(konst[BASE_W-1:0]);
            AM_ABS23: addr = konst;
            default:  flags.ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/pda_gen.sv
module pda_gen
    import pda_pkg::*;
#(
    parameter int PAGE_W    = PAGE_W_D,
    parameter int BASE_W    = BASE_W_D,
    parameter int OFS_W     = OFS_W_D,
    parameter int PORT_PG_W = PORT_PG_W_D,
    parameter int MMR_END   = MMR_END_D,
    localparam int ADDR_W   = PAGE_W + BASE_W,
    localparam int PORT_W   = PORT_PG_W + OFS_W,
    localparam int N_PAGED  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [1:0]        ld_sel,
    input  logic [1:0]        ld_part,
    input  logic [ADDR_W-1:0] ld_value,
    input  logic              req_valid,
    input  logic [2:0]        req_mode,
    input  logic              req_mmr,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [ADDR_W-1:0] req_const,
    output logic              out_valid,
    output logic              out_is_io,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_rsvd
);

    logic [PAGE_W-1:0]    pg_hi [N_PAGED];
    logic [BASE_W-1:0]    pg_lo [N_PAGED];
    logic [PORT_PG_W-1:0] pp_hi;
    logic [OFS_W-1:0]     pp_lo_unused;

    logic [ADDR_W-1:0]    nxt_addr;
    addr_flags_t          nxt_flags;

    // data pointer (index 0) and stack pointer (index 1) share one layout
    for (genvar g = 0; g < N_PAGED; g++) begin : g_paged
        pda_ptr_reg #(.HI_W(PAGE_W), .LO_W(BASE_W)) u_ptr (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (ld_valid && (ld_sel == 2'(g))),
            .wr_part (ld_part_e'(ld_part)),
            .wr_data (ld_value),
            .hi      (pg_hi[g]),
            .lo      (pg_lo[g])
        );
    end

    pda_ptr_reg #(.HI_W(PORT_PG_W), .LO_W(OFS_W)) u_port_ptr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ld_valid && (ptr_sel_e'(ld_sel) == PS_PORT)),
        .wr_part (ld_part_e'(ld_part)),
        .wr_data (ld_value[PORT_W-1:0]),
        .hi      (pp_hi),
        .lo      (pp_lo_unused)
    );

    pda_addr_form #(
        .PAGE_W    (PAGE_W),
        .BASE_W    (BASE_W),
        .OFS_W     (OFS_W),
        .PORT_PG_W (PORT_PG_W),
        .MMR_END   (MMR_END)
    ) u_form (
        .mode   (amode_e'(req_mode)),
        .mmr    (req_mmr),
        .offset (req_offset),
        .konst  (req_const),
        .dp_hi  (pg_hi[0]),
        .dp_lo  (pg_lo[0]),
        .sp_hi  (pg_hi[1]),
        .sp_lo  (pg_lo[1]),
        .pp_hi  (pp_hi),
        .addr   (nxt_addr),
        .flags  (nxt_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_is_io <= 1'b0;
            out_rsvd  <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= req_valid && nxt_flags.ok;
            if (req_valid && nxt_flags.ok) begin
                out_addr  <= nxt_addr;
                out_is_io <= nxt_flags.is_io;
                out_rsvd  <= nxt_flags.rsvd;
            end
        end
    end

endmodule

// File: rtl/pda_gen_chk.sv
module pda_gen_chk #(
    parameter int ADDR_W = 23,
    parameter int OFS_W  = 7,
    parameter int MMR_END = 'h60
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [2:0]        req_mode,
    input logic              req_mmr,
    input logic [OFS_W-1:0]  req_offset,
    input logic [ADDR_W-1:0] req_const,
    input logic              out_valid,
    input logic              out_is_io,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_rsvd
);

    // R10
    strobe_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode <= 3'd4) |=> out_valid);

    // R10
    no_strobe_without_req_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_mode <= 3'd4) |=> !out_valid);

    // R9
    abs_wide_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 3'd4) |=> (out_addr == $past(req_const) && !out_is_io));

    // R8
    abs_short_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 3'd3) |=>
            (out_addr == ADDR_W'($past(req_const[15:0])) && !out_is_io));

    // R7
    port_space_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 3'd2) |=>
            (out_is_io && out_addr[ADDR_W-1:16] == '0 &&
             out_addr[OFS_W-1:0] == $past(req_offset)));

    // R4
    mmr_page0_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 3'd0 && req_mmr) |=>
            (out_addr == ADDR_W'($past(req_offset))));

    // R6
    rsvd_stack_only_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode != 3'd1 && req_mode <= 3'd4) |=> !out_rsvd);

    // R6
    rsvd_range_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_rsvd) |-> (out_addr < ADDR_W'(MMR_END)));

endmodule

bind pda_gen pda_gen_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .MMR_END(MMR_END)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .req_mmr    (req_mmr),
    .req_offset (req_offset),
    .req_const  (req_const),
    .out_valid  (out_valid),
    .out_is_io  (out_is_io),
    .out_addr   (out_addr),
    .out_rsvd   (out_rsvd)
);

// File: tb/pda_gen_test.sv
module pda_gen_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_valid;
    logic [1:0]  ld_sel;
    logic [1:0]  ld_part;
    logic [22:0] ld_value;
    logic        req_valid;
    logic [2:0]  req_mode;
    logic        req_mmr;
    logic [6:0]  req_offset;
    logic [22:0] req_const;
    logic        out_valid;
    logic        out_is_io;
    logic [22:0] out_addr;
    logic        out_rsvd;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pda_gen uut (
        .clk(clk), .rst(rst),
        .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_part(ld_part), .ld_value(ld_value),
        .req_valid(req_valid), .req_mode(req_mode), .req_mmr(req_mmr),
        .req_offset(req_offset), .req_const(req_const),
        .out_valid(out_valid), .out_is_io(out_is_io), .out_addr(out_addr), .out_rsvd(out_rsvd)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic do_load(input logic [1:0] sel, input logic [1:0] part, input logic [22:0] val);
        @(negedge clk);
        ld_valid = 1'b1; ld_sel = sel; ld_part = part; ld_value = val;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // drive a request at a falling edge, sample one cycle later at the next falling edge
    task automatic do_req(input logic [2:0] mode, input logic mmr,
                          input logic [6:0] ofs, input logic [22:0] k);
        @(negedge clk);
        req_valid = 1'b1; req_mode = mode; req_mmr = mmr; req_offset = ofs; req_const = k;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 valid", out_valid, 0);
        check("R1 addr", out_addr, 0);
        check("R1 io", out_is_io, 0);
        check("R1 rsvd", out_rsvd, 0);
        do_req(3'd0, 1'b0, 7'h00, '0);
        check("R1 data ptr zero", out_addr, 0);
    endtask

    task automatic t_page;
        do_load(2'd0, 2'd0, 23'h03);
        do_load(2'd0, 2'd1, 23'h0100);
        do_req(3'd0, 1'b0, 7'h05, '0);
        check("R3 page addr", out_addr, 32'h030105);
        check("R10 strobe", out_valid, 1);
        check("R7 not io", out_is_io, 0);
        @(negedge clk);
        check("R10 strobe drops", out_valid, 0);
        check("R10 addr held", out_addr, 32'h030105);
    endtask

    task automatic t_wrap;
        do_load(2'd0, 2'd2, 23'h01FFEF);
        do_req(3'd0, 1'b0, 7'h20, '0);
        check("R3 wrap no carry", out_addr, 32'h01000F);
    endtask

    task automatic t_parts;
        do_load(2'd0, 2'd2, 23'h014000);
        do_req(3'd0, 1'b0, 7'h00, '0);
        check("R2 full load", out_addr, 32'h014000);
        do_load(2'd0, 2'd0, 23'h7FFF7F);
        do_req(3'd0, 1'b0, 7'h00, '0);
        check("R2 high only", out_addr, 32'h7F4000);
        do_load(2'd0, 2'd1, 23'h7F1234);
        do_req(3'd0, 1'b0, 7'h00, '0);
        check("R2 low only", out_addr, 32'h7F1234);
        do_load(2'd3, 2'd2, 23'h000000);
        do_req(3'd0, 1'b0, 7'h00, '0);
        check("R2 select none", out_addr, 32'h7F1234);
    endtask

    task automatic t_mmr;
        do_req(3'd0, 1'b1, 7'h08, '0);
        check("R4 mmr override", out_addr, 32'h000008);
        do_load(2'd1, 2'd2, 23'h020300);
        do_req(3'd1, 1'b1, 7'h01, '0);
        check("R4 mmr ignored in stack", out_addr, 32'h020301);
        check("R5 stack addr", out_addr, 32'h020301);
        check("R6 page nonzero", out_rsvd, 0);
    endtask

    task automatic t_rsvd;
        do_load(2'd1, 2'd2, 23'h000050);
        do_req(3'd1, 1'b0, 7'h0F, '0);
        check("R6 last reserved", out_rsvd, 1);
        check("R5 stack low", out_addr, 32'h00005F);
        do_req(3'd1, 1'b0, 7'h10, '0);
        check("R6 first free", out_rsvd, 0);
        do_load(2'd1, 2'd1, 23'h00FFF0);
        do_req(3'd1, 1'b0, 7'h20, '0);
        check("R6 wrapped into region", out_rsvd, 1);
        check("R5 stack wrap", out_addr, 32'h000010);
        do_load(2'd0, 2'd2, 23'h000000);
        do_req(3'd0, 1'b0, 7'h10, '0);
        check("R6 data mode no flag", out_rsvd, 0);
    endtask

    task automatic t_port;
        do_load(2'd2, 2'd0, 23'h0001A5);
        do_req(3'd2, 1'b0, 7'h33, '0);
        check("R7 io addr", out_addr, 32'h00D2B3);
        check("R7 io flag", out_is_io, 1);
        do_load(2'd2, 2'd1, 23'h00007F);
        do_req(3'd2, 1'b1, 7'h01, '0);
        check("R2 port low field unused", out_addr, 32'h00D281);
    endtask

    task automatic t_abs;
        do_req(3'd3, 1'b0, 7'h00, 23'h7FABCD);
        check("R8 abs16", out_addr, 32'h00ABCD);
        check("R7 abs16 not io", out_is_io, 0);
        do_req(3'd4, 1'b1, 7'h7F, 23'h011234);
        check("R9 abs23", out_addr, 32'h011234);
    endtask

    task automatic t_illegal;
        do_req(3'd5, 1'b0, 7'h01, 23'h000777);
        check("R10 illegal mode strobe", out_valid, 0);
        check("R10 illegal mode addr held", out_addr, 32'h011234);
        do_req(3'd7, 1'b0, 7'h01, 23'h000777);
        check("R10 mode 7 strobe", out_valid, 0);
    endtask

    task automatic t_same_cycle;
        do_load(2'd0, 2'd2, 23'h050200);
        @(negedge clk);
        ld_valid = 1'b1; ld_sel = 2'd0; ld_part = 2'd2; ld_value = 23'h060400;
        req_valid = 1'b1; req_mode = 3'd0; req_mmr = 1'b0; req_offset = 7'h02; req_const = '0;
        @(negedge clk);
        ld_valid = 1'b0; req_valid = 1'b0;
        check("R11 old pointer used", out_addr, 32'h050202);
        do_req(3'd0, 1'b0, 7'h02, '0);
        check("R11 new pointer after", out_addr, 32'h060402);
    endtask

    initial begin
        rst = 1'b1; ld_valid = 1'b0; ld_sel = '0; ld_part = '0; ld_value = '0;
        req_valid = 1'b0; req_mode = '0; req_mmr = 1'b0; req_offset = '0; req_const = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_page();
        t_wrap();
        t_parts();
        t_mmr();
        t_rsvd();
        t_port();
        t_abs();
        t_illegal();
        t_same_cycle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule